// File: doc/BRIEF.md
# Per-Core Deadline Event Timer

This block is a local event timer that sits beside one processor core. A 64-bit system counter advances by one on every cycle in which the tick enable input is high. Software arms a deadline by writing a signed 32-bit count of ticks relative to the present counter value. The block turns that count into an absolute 64-bit compare value. Once the counter reaches or passes the compare value while the timer is enabled, a status flag rises. A level interrupt is driven whenever that flag is set and the interrupt is not masked.

Software reaches the block through a small 32-bit register bus. Reads return data in the same cycle. Writes take effect at the clock edge. Software acknowledges an event by setting the mask bit: the status flag stays set until a new deadline is armed or the timer is disabled. A second, virtual counter view returns the physical count minus a software-written 64-bit offset. Each counter view is read as a low word followed by a high word. Reading the low word captures the matching high word, so the pair stays consistent even when a carry falls between the two reads.

Top module: `etmr_top`

## Requirements
- R1: The control register sits at word address 0. Bit 0 is enable, bit 1 is mask and bit 2 is the read-only status flag. All three read 0 after reset, and a write changes only bits 0 and 1.
- R2: The frequency register at word address 1 returns the nonzero parameter FREQ_VAL. Writes to it have no effect.
- R3: The physical counter resets to 0 and increases by exactly one at each clock edge where tick_en is high. Its low word is read at address 4.
- R4: A read of address 4 captures counter bits 63:32 into a shadow register at that edge. Address 5 returns the shadow, so a low/high read pair forms one 64-bit snapshot.
- R5: A write to address 2 sets compare = counter + the sign-extended write data, using the counter value before that edge. A read of address 2 returns bits 31:0 of compare minus counter.
- R6: The status flag is set exactly when enable is 1 and (counter minus compare), taken as a signed 64-bit number, is zero or positive.
- R7: irq_o equals the status flag AND NOT mask. Setting mask silences irq_o and leaves the status flag set.
- R8: Writing 0 to the control register clears the status flag and irq_o from the next cycle on.
- R9: The virtual view equals the counter minus a 64-bit offset. The offset halves are written and read at address 8 (low) and address 9 (high). The view's low word is read at address 6, which captures its high word for address 7.
- R10: Deadlines from 0xF to 0x7FFFFFFF ticks are handled without signed overflow. An armed deadline of N ticks raises the status flag after exactly N counting edges and not before. Written values of 0x80000000 and above count as deadlines already in the past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of events can fall in the same cycle: a counter tick with a deadline write, and a counter tick with a low-word read. In both cases the value from before the edge must be used, both for the compare sum and for the captured high word. The bench raises tick_en during most register accesses, including directed low/high pairs taken across a 32-bit carry of the virtual view. A bench model that applies the access before the increment judges each readout and the interrupt level. Deadline firing is also judged by counting tick edges until irq_o rises.

// File: rtl/etmr_pkg.sv
`timescale 1ns/1ps
package etmr_pkg;
  localparam int DW = 32;
  localparam int CW = 2 * DW;
  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    A_CTRL = 4'h0,
    A_FREQ = 4'h1,
    A_TVAL = 4'h2,
    A_CLO  = 4'h4,
    A_CHI  = 4'h5,
    A_VLO  = 4'h6,
    A_VHI  = 4'h7,
    A_OLO  = 4'h8,
    A_OHI  = 4'h9
  } reg_addr_e;

  typedef struct packed {
    logic imask;
    logic enable;
  } ctrl_t;

  // Widen a signed relative count to counter width.
  function automatic logic [CW-1:0] sext_word(input logic [DW-1:0] v);
    return {{DW{v[DW-1]}}, v};
  endfunction

  // Absolute compare value from a relative deadline.
  function automatic logic [CW-1:0] arm_compare(input logic [CW-1:0] cnt,
                                                input logic [DW-1:0] rel);
    return cnt + sext_word(rel);
  endfunction

  // Deadline reached when (cnt - cmp) is non-negative as a signed number.
  function automatic logic deadline_reached(input logic [CW-1:0] cnt,
                                            input logic [CW-1:0] cmp);
    logic [CW-1:0] diff;
    diff = cnt - cmp;
    return ~diff[CW-1];
  endfunction

  // Ticks left until the deadline, truncated to a bus word.
  function automatic logic [DW-1:0] remaining(input logic [CW-1:0] cmp,
                                              input logic [CW-1:0] cnt);
    logic [CW-1:0] diff;
    diff = cmp - cnt;
    return diff[DW-1:0];
  endfunction

  // Virtual counter view.
  function automatic logic [CW-1:0] virt_view(input logic [CW-1:0] cnt,
                                              input logic [CW-1:0] off);
    return cnt - off;
  endfunction
endpackage

// File: rtl/etmr_counter.sv
`timescale 1ns/1ps
module etmr_counter
  import etmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          off_lo_wr,
  input  logic          off_hi_wr,
  input  logic [DW-1:0] wdata,
  input  logic          phys_lo_rd,
  input  logic          virt_lo_rd,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] voff,
  output logic [CW-1:0] vcnt,
  output logic [DW-1:0] phys_hi_shadow,
  output logic [DW-1:0] virt_hi_shadow
);
  localparam int NVIEW = 2;

  logic [CW-1:0] view_val [NVIEW];
  logic          view_rd  [NVIEW];
  logic [DW-1:0] view_sh  [NVIEW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick_en) cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) voff <= '0;
    else begin
      if (off_lo_wr) voff[DW-1:0] <= wdata;
      if (off_hi_wr) voff[CW-1:DW] <= wdata;
    end
  end

  assign vcnt = virt_view(cnt, voff);

  assign view_val[0] = cnt;
  assign view_val[1] = vcnt;
  assign view_rd[0]  = phys_lo_rd;
  assign view_rd[1]  = virt_lo_rd;

  // One high-word capture register per counter view.
  for (genvar g = 0; g < NVIEW; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) view_sh[g] <= '0;
      else if (view_rd[g]) view_sh[g] <= view_val[g][CW-1:DW];
    end
  end

  assign phys_hi_shadow = view_sh[0];
  assign virt_hi_shadow = view_sh[1];
endmodule

// File: rtl/etmr_compare.sv
`timescale 1ns/1ps
module etmr_compare
  import etmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          ctrl_wr,
  input  logic          tval_wr,
  input  logic [DW-1:0] wdata,
  output logic          enable,
  output logic          imask,
  output logic          istatus,
  output logic          irq,
  output logic [CW-1:0] cmp,
  output logic [DW-1:0] tval_now
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else if (tval_wr) cmp <= arm_compare(cnt, wdata);
  end

  assign enable   = ctrl_q.enable;
  assign imask    = ctrl_q.imask;
  assign istatus  = enable & deadline_reached(cnt, cmp);
  assign irq      = istatus & ~imask;
  assign tval_now = remaining(cmp, cnt);
endmodule

// File: rtl/etmr_regif.sv
`timescale 1ns/1ps
module etmr_regif
  import etmr_pkg::*;
#(
  parameter logic [DW-1:0] FREQ_VAL = 32'd50_000_000
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          enable,
  input  logic          imask,
  input  logic          istatus,
  input  logic [DW-1:0] tval_now,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] vcnt,
  input  logic [CW-1:0] voff,
  input  logic [DW-1:0] phys_hi_shadow,
  input  logic [DW-1:0] virt_hi_shadow,
  output logic          ctrl_wr,
  output logic          tval_wr,
  output logic          off_lo_wr,
  output logic          off_hi_wr,
  output logic          phys_lo_rd,
  output logic          virt_lo_rd,
  output logic [DW-1:0] bus_rdata
);
  reg_addr_e a;
  assign a = reg_addr_e'(bus_addr);

  assign ctrl_wr    = bus_wr && (a == A_CTRL);
  assign tval_wr    = bus_wr && (a == A_TVAL);
  assign off_lo_wr  = bus_wr && (a == A_OLO);
  assign off_hi_wr  = bus_wr && (a == A_OHI);
  assign phys_lo_rd = bus_rd && (a == A_CLO);
  assign virt_lo_rd = bus_rd && (a == A_VLO);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (a)
        A_CTRL:  bus_rdata = {{(DW-3){1'b0}}, istatus, imask, enable};
        A_FREQ:  bus_rdata = FREQ_VAL;
        A_TVAL:  bus_rdata = tval_now;
        A_CLO:   bus_rdata = cnt[DW-1:0];
        A_CHI:   bus_rdata = phys_hi_shadow;
        A_VLO:   bus_rdata = vcnt[DW-1:0];
        A_VHI:   bus_rdata = virt_hi_shadow;
        A_OLO:   bus_rdata = voff[DW-1:0];
        A_OHI:   bus_rdata = voff[CW-1:DW];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/etmr_top.sv
`timescale 1ns/1ps
module etmr_top
  import etmr_pkg::*;
#(
  parameter logic [31:0] FREQ_VAL = 32'd50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  // Named internal events, visible to the bound checker.
  logic          ctrl_wr, tval_wr, off_lo_wr, off_hi_wr;
  logic          phys_lo_rd, virt_lo_rd;
  logic          enable, imask, istatus, irq;
  logic [CW-1:0] cnt, vcnt, voff, cmp;
  logic [DW-1:0] tval_now, phys_hi_shadow, virt_hi_shadow;

  etmr_regif #(.FREQ_VAL(FREQ_VAL)) u_regif (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .enable(enable), .imask(imask), .istatus(istatus), .tval_now(tval_now),
    .cnt(cnt), .vcnt(vcnt), .voff(voff),
    .phys_hi_shadow(phys_hi_shadow), .virt_hi_shadow(virt_hi_shadow),
    .ctrl_wr(ctrl_wr), .tval_wr(tval_wr), .off_lo_wr(off_lo_wr),
    .off_hi_wr(off_hi_wr), .phys_lo_rd(phys_lo_rd), .virt_lo_rd(virt_lo_rd),
    .bus_rdata(bus_rdata)
  );

  etmr_counter u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .off_lo_wr(off_lo_wr), .off_hi_wr(off_hi_wr), .wdata(bus_wdata),
    .phys_lo_rd(phys_lo_rd), .virt_lo_rd(virt_lo_rd),
    .cnt(cnt), .voff(voff), .vcnt(vcnt),
    .phys_hi_shadow(phys_hi_shadow), .virt_hi_shadow(virt_hi_shadow)
  );

  etmr_compare u_compare (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .ctrl_wr(ctrl_wr), .tval_wr(tval_wr), .wdata(bus_wdata),
    .enable(enable), .imask(imask), .istatus(istatus), .irq(irq),
    .cmp(cmp), .tval_now(tval_now)
  );

  assign irq_o = irq;
endmodule

// File: rtl/etmr_checker.sv
`timescale 1ns/1ps
module etmr_checker
  import etmr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          ctrl_wr,
  input logic          tval_wr,
  input logic          phys_lo_rd,
  input logic [DW-1:0] wdata,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] voff,
  input logic [DW-1:0] phys_hi_shadow,
  input logic          enable,
  input logic          imask,
  input logic          istatus,
  input logic          irq_o
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + {{(CW-1){1'b0}}, $past(tick_en)});

  assert_shadow_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(phys_lo_rd)) |-> phys_hi_shadow == $past(cnt[CW-1:DW]));

  assert_arm_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tval_wr)) |-> cmp == $past(cnt) + {{DW{$past(wdata[DW-1])}}, $past(wdata)});

  assert_status_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    istatus |-> enable);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (istatus && !imask));

  assert_irq_when_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (istatus && !imask) |-> irq_o);

  assert_idle_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[1:0] == 2'b00) |=> (!istatus && !irq_o));

  assert_virt_view_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt + voff == cnt);

  assert_fire_on_reach_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt == cmp) |-> istatus);
endmodule

bind etmr_top etmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .ctrl_wr(ctrl_wr), .tval_wr(tval_wr), .phys_lo_rd(phys_lo_rd),
  .wdata(bus_wdata), .cnt(cnt), .cmp(cmp), .vcnt(vcnt), .voff(voff),
  .phys_hi_shadow(phys_hi_shadow), .enable(enable), .imask(imask),
  .istatus(istatus), .irq_o(irq_o)
);

// File: tb/tb_etmr_top.sv
`timescale 1ns/1ps
module tb_etmr_top;
  localparam logic [31:0] FREQ = 32'd24_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  etmr_top #(.FREQ_VAL(FREQ)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Bench model state
  logic [63:0] m_cnt = '0, m_cmp = '0, m_off = '0;
  logic [31:0] m_shp = '0, m_shv = '0;
  bit m_en = 0, m_mask = 0;

  function automatic bit m_status();
    logic signed [63:0] d;
    d = $signed(m_cnt) - $signed(m_cmp);
    return m_en && (d >= 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [63:0] v;
    v = m_cnt - m_off;
    case (a)
      4'h0: return {29'd0, m_status(), m_mask, m_en};
      4'h1: return FREQ;
      4'h2: return 32'(m_cmp - m_cnt);
      4'h4: return m_cnt[31:0];
      4'h5: return m_shp;
      4'h6: return v[31:0];
      4'h7: return m_shv;
      4'h8: return m_off[31:0];
      4'h9: return m_off[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample before the rising edge, update model.
  task automatic cyc(input bit wr, input bit rd, input logic [3:0] a,
                     input logic [31:0] d, input bit tk, input string tag);
    logic [63:0] v;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk;
    #2;
    if (rd) check(tag, {32'd0, bus_rdata}, {32'd0, m_read(a)});
    check("R7 irq level", {63'd0, irq_o}, {63'd0, m_status() && !m_mask});
    v = m_cnt - m_off;
    if (rd && a == 4'h4) m_shp = m_cnt[63:32];
    if (rd && a == 4'h6) m_shv = v[63:32];
    if (wr) begin
      case (a)
        4'h0: begin m_en = d[0]; m_mask = d[1]; end
        4'h2: m_cmp = m_cnt + {{32{d[31]}}, d};
        4'h8: m_off[31:0] = d;
        4'h9: m_off[63:32] = d;
        default: ;
      endcase
    end
    if (tk) m_cnt = m_cnt + 64'd1;
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit tk, input string tag);
    cyc(1, 0, a, d, tk, tag);
  endtask

  task automatic rd(input logic [3:0] a, input bit tk, input string tag);
    cyc(0, 1, a, 32'd0, tk, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_200_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state
    rd(4'h0, 0, "R1 control after reset");
    rd(4'h4, 0, "R3 counter low after reset");
    rd(4'h5, 0, "R4 shadow after reset");
    rd(4'h1, 0, "R2 frequency value");
    wr(4'h1, 32'hDEAD_BEEF, 1, "R2 write to frequency");
    rd(4'h1, 1, "R2 frequency unchanged");

    // Control layout: status bit is not writable
    wr(4'h0, 32'hFFFF_FFFC, 0, "R1 write with status bit");
    rd(4'h0, 0, "R1 only bits 0 and 1 taken");
    wr(4'h0, 32'h0000_0007, 1, "R1 write all ones");
    rd(4'h0, 1, "R1 readback with status");
    wr(4'h0, 32'h0, 1, "R8 idle write");
    rd(4'h0, 0, "R8 control idle");

    // Counter and shadow, tick during the low read
    repeat (20) cyc(0, 0, 4'h0, 0, 1, "R3 ticking");
    rd(4'h4, 1, "R3 counter low with tick");
    rd(4'h5, 1, "R4 high from shadow");

    // Minimum deadline fires after exactly 15 ticks
    wr(4'h0, 32'h1, 0, "R1 enable");
    wr(4'h2, 32'h0000_000F, 0, "R5 arm 0xF");
    rd(4'h2, 0, "R5 remaining 0xF");
    n = 0;
    while (!irq_o && n < 100) begin
      cyc(0, 0, 4'h0, 0, 1, "R10 wait");
      #1;
      n++;
    end
    check("R10 ticks to fire 0xF", 64'(n), 64'd15);
    rd(4'h2, 0, "R5 remaining at zero");

    // Mask acknowledges without clearing status
    wr(4'h0, 32'h3, 1, "R7 set mask");
    #1 check("R7 irq off under mask", {63'd0, irq_o}, 64'd0);
    rd(4'h0, 1, "R7 status kept under mask");
    wr(4'h0, 32'h0, 1, "R8 disable");
    #1 check("R8 irq off after disable", {63'd0, irq_o}, 64'd0);
    rd(4'h0, 0, "R8 status cleared");

    // Largest positive deadline does not fire
    wr(4'h0, 32'h1, 1, "R6 enable");
    wr(4'h2, 32'h7FFF_FFFF, 1, "R10 arm max");
    repeat (50) cyc(0, 0, 4'h0, 0, 1, "R10 wait max");
    rd(4'h2, 0, "R10 remaining after 50 ticks");
    rd(4'h0, 0, "R10 not fired at max");
    // Negative values are already past
    wr(4'h2, 32'h8000_0000, 0, "R10 arm 0x80000000");
    rd(4'h0, 0, "R10 past deadline status");
    wr(4'h2, 32'hFFFF_FFFF, 1, "R6 arm minus one");
    rd(4'h0, 1, "R6 status on past deadline");
    wr(4'h2, 32'h0000_0000, 1, "R6 arm zero");
    rd(4'h0, 0, "R6 status on zero deadline");

    // Virtual view across a 32-bit carry
    wr(4'h8, m_cnt[31:0] + 32'd8, 0, "R9 offset low");
    wr(4'h9, 32'h0, 0, "R9 offset high");
    rd(4'h8, 0, "R9 offset low readback");
    rd(4'h9, 0, "R9 offset high readback");
    for (int i = 0; i < 12; i++) begin
      rd(4'h6, 1, "R9 virtual low with tick");
      rd(4'h7, 1, "R9 virtual high from shadow");
    end

    // Random mix
    for (int i = 0; i < 800; i++) begin
      int op;
      logic [31:0] d;
      bit tk;
      op = $urandom_range(0, 9);
      tk = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 3))
        0: d = 32'h0000_000F + $urandom_range(0, 40);
        1: d = $urandom_range(0, 30);
        2: d = 32'hFFFF_FFFF - $urandom_range(0, 20);
        default: d = $urandom & 32'h7FFF_FFFF;
      endcase
      case (op)
        0: wr(4'h0, $urandom, tk, "R1 random control");
        1: wr(4'h2, d, tk, "R5 random arm");
        2: rd(4'h2, tk, "R5 random remaining");
        3, 4: rd(4'h0, tk, "R6 random status");
        5: rd(4'h4, tk, "R3 random low");
        6: rd(4'h5, tk, "R4 random high");
        7: rd(4'h6, tk, "R9 random virtual low");
        8: rd(4'h7, tk, "R9 random virtual high");
        default: cyc(0, 0, 4'h0, 0, tk, "R10 random idle");
      endcase
    end

    finish_run();
  end
endmodule